// File: doc/BRIEF.md
# Locality Interrupt Enable and Status Unit

This unit keeps the interrupt configuration and the pending interrupt events for five independent register windows, called localities. Each locality has its own enable register and its own status register. All localities share one interrupt output line. Events arrive as one-cycle strobes, each tagged with a target locality. The locality arbiter reports a change of owner. The command engine reports data-available, status-valid and command-ready. An event is recorded, and the line raised, only when the target locality has set both its global enable and the enable for that event.

Software sees the unit through a simple register port. Each access carries a locality number, a window offset and, for writes, a data word. Only the locality that is currently active may change the enable and status registers. Writes from any other locality have no effect. Status bits are cleared by writing ones. The line falls when a clearing write leaves the writing locality's status empty, even if another locality still has bits pending. Two read-only registers report the fixed interrupt line number and the set of supported events. Support for the status-valid event is a build-time choice.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset, every locality's enable register reads 0x00000008 (low-level polarity code only), every status register reads 0, and `irq_line` is low.
- R2: A write to the enable register (offset 0x08) keeps only bit 31 (global enable), bits 4:3 (polarity) and the supported event bits, and clears every other bit. Writing 0xFFFFFFFF therefore reads back 0x8000009F when status-valid is supported.
- R3: The event bits are bit 0 (data-available), bit 1 (status-valid), bit 2 (locality-changed) and bit 7 (command-ready). The arbiter strobe sets bit 2, and the engine strobe presents any of bits 0, 1 and 7. An event sets its status bit, and `irq_line` is high from the next clock edge, only when the target locality has bit 31 and that event's bit set in its enable register. Otherwise nothing changes.
- R4: A write to the status register (offset 0x10) clears exactly the supported bits written as one. Bits written as zero keep their value.
- R5: When a clearing status write leaves the writing locality's status at zero, `irq_line` is low from the next edge, even if another locality still has bits pending. If any status bit remains set in the writing locality, the line keeps its value.
- R6: Writes to the enable and status registers have no effect unless `act_vld` is high and `act_loc` equals `reg_loc`.
- R7: The vector register (offset 0x0C) reads the parameter LINE_NUM (range 0 to 15) in bits 3:0, with all other bits zero. Writes to it are ignored.
- R8: The capability register (offset 0x14) reads the supported event mask OR'd with bit 4, which reports low-level line support. The value is 0x00000097 when status-valid is supported.
- R9: With STS_VALID_EN=0, status-valid is not supported. Bit 1 is dropped from enable writes, is never set in status, and is absent from the capability value (0x00000095).
- R10: If an event sets a status bit in the same cycle that a write clears it, the event wins: the bit stays set and the line is high.
- R11: Reads from unmapped offsets return 0. Enable and status reads for a locality number of 5 or above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| act_vld | input | 1 | An active locality exists |
| act_loc | input | 3 | Number of the active locality |
| reg_wr | input | 1 | Register write strobe |
| reg_loc | input | 3 | Locality number of the register access |
| reg_off | input | 12 | Offset within the locality window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_loc` and `reg_off` |
| arb_chg_vld | input | 1 | Locality-changed event strobe |
| arb_chg_loc | input | 3 | Target locality of the locality-changed event |
| eng_evt_vld | input | 1 | Command engine event strobe |
| eng_evt_loc | input | 3 | Target locality of the engine event |
| eng_evt_bits | input | 8 | Engine event bits, positioned as in the status register |
| irq_line | output | 1 | Shared interrupt line, active high |

## Verification
The assertions take for granted that event strobes last one cycle and that the register port's offset and locality inputs are stable while `reg_wr` is high. They also take for granted that an engine strobe carries only bits that name engine events. The stimulus drives every input at the falling edge and holds it for exactly one clock cycle. Its engine masks are always drawn from bits 0, 1 and 7, and the active locality is sometimes absent and sometimes out of range. This exercises both the accepted-write and the ignored-write paths while still respecting those assumptions.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned STS_W    = 8;
  localparam int unsigned BIT_DAV  = 0;
  localparam int unsigned BIT_SVL  = 1;
  localparam int unsigned BIT_LCH  = 2;
  localparam int unsigned BIT_CRDY = 7;
  localparam int unsigned BIT_GEN  = 31;

  localparam logic [31:0] POL_FIELD  = 32'h0000_0018;
  localparam logic [31:0] POL_LOWLVL = 32'h0000_0008;
  localparam logic [31:0] CAP_LOWLVL = 32'h0000_0010;

  localparam int unsigned OFF_EN  = 'h08;
  localparam int unsigned OFF_VEC = 'h0C;
  localparam int unsigned OFF_STS = 'h10;
  localparam int unsigned OFF_CAP = 'h14;

  function automatic logic [STS_W-1:0] sup_mask(input bit svl_en);
    logic [STS_W-1:0] m;
    m = '0;
    m[BIT_DAV]  = 1'b1;
    m[BIT_LCH]  = 1'b1;
    m[BIT_CRDY] = 1'b1;
    m[BIT_SVL]  = svl_en;
    return m;
  endfunction

  function automatic logic [31:0] en_mask(input bit svl_en);
    logic [31:0] m;
    m = POL_FIELD | {24'h0, sup_mask(svl_en)};
    m[BIT_GEN] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lirq_loc_regs.sv
module lirq_loc_regs
  import lirq_pkg::*;
#(
  parameter logic [STS_W-1:0] SUP   = 8'h87,
  parameter logic [31:0]      EMASK = 32'h8000_009F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             sts_we,
  input  logic [31:0]      wdata,
  input  logic [STS_W-1:0] evt_bits,
  output logic [31:0]      en_q,
  output logic [STS_W-1:0] sts_q,
  output logic             hit,
  output logic             clr_zero
);
  logic [STS_W-1:0] qual;
  logic [STS_W-1:0] clr;
  logic [STS_W-1:0] sts_d;
  logic [31:0]      en_d;
  logic             en_ld;
  logic             sts_ld;

  always_comb begin
    qual     = en_q[BIT_GEN] ? (evt_bits & en_q[STS_W-1:0] & SUP) : '0;
    clr      = sts_we ? (wdata[STS_W-1:0] & SUP) : '0;
    sts_d    = (sts_q & ~clr) | qual;
    en_d     = wdata & EMASK;
    hit      = |qual;
    clr_zero = sts_we && (|clr) && (|(sts_q & SUP)) && (sts_d == '0);
    en_ld    = en_we;
    sts_ld   = sts_we || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= POL_LOWLVL;
      sts_q <= '0;
    end else begin
      if (en_ld)  en_q  <= en_d;
      if (sts_ld) sts_q <= sts_d;
    end
  end
endmodule

// File: rtl/lirq_line_ctl.sv
module lirq_line_ctl #(
  parameter int unsigned NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] set_vec,
  input  logic [NUM_LOC-1:0] drop_vec,
  output logic               line_q
);
  logic line_d;
  logic line_ld;

  always_comb begin
    line_ld = (|set_vec) || (|drop_vec);
    line_d  = |set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= 1'b0;
    else if (line_ld) line_q <= line_d;
  end
endmodule

// File: rtl/loc_irq_unit.sv
module loc_irq_unit
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_LOC     = 5,
  parameter int unsigned LOC_W       = 3,
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned LINE_NUM    = 11,
  parameter bit          STS_VALID_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_vld,
  input  logic [LOC_W-1:0] act_loc,
  input  logic             reg_wr,
  input  logic [LOC_W-1:0] reg_loc,
  input  logic [OFF_W-1:0] reg_off,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             arb_chg_vld,
  input  logic [LOC_W-1:0] arb_chg_loc,
  input  logic             eng_evt_vld,
  input  logic [LOC_W-1:0] eng_evt_loc,
  input  logic [STS_W-1:0] eng_evt_bits,
  output logic             irq_line
);
  localparam logic [STS_W-1:0] SUP   = sup_mask(STS_VALID_EN);
  localparam logic [31:0]      EMASK = en_mask(STS_VALID_EN);
  localparam logic [31:0]      CAP   = CAP_LOWLVL | {24'h0, SUP};
  localparam logic [31:0]      VEC   = 32'(LINE_NUM & 4'hF);
  localparam logic [OFF_W-1:0] A_EN  = OFF_W'(OFF_EN);
  localparam logic [OFF_W-1:0] A_VEC = OFF_W'(OFF_VEC);
  localparam logic [OFF_W-1:0] A_STS = OFF_W'(OFF_STS);
  localparam logic [OFF_W-1:0] A_CAP = OFF_W'(OFF_CAP);

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic                     wr_ok;
  logic [NUM_LOC-1:0]       hit_vec;
  logic [NUM_LOC-1:0]       clr_zero_vec;
  logic [NUM_LOC*32-1:0]    en_flat;
  logic [NUM_LOC*STS_W-1:0] sts_flat;

  assign wr_ok = reg_wr && act_vld && (act_loc == reg_loc);

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_loc
    logic             en_we;
    logic             sts_we;
    logic [STS_W-1:0] evt;
    always_comb begin
      en_we  = wr_ok && (reg_loc == LOC_W'(l)) && (reg_off == A_EN);
      sts_we = wr_ok && (reg_loc == LOC_W'(l)) && (reg_off == A_STS);
      evt    = '0;
      if (arb_chg_vld && arb_chg_loc == LOC_W'(l)) evt[BIT_LCH] = 1'b1;
      if (eng_evt_vld && eng_evt_loc == LOC_W'(l)) evt = evt | eng_evt_bits;
    end
    lirq_loc_regs #(.SUP(SUP), .EMASK(EMASK)) u_regs (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .en_we    (en_we),
      .sts_we   (sts_we),
      .wdata    (reg_wdata),
      .evt_bits (evt),
      .en_q     (en_flat[l*32 +: 32]),
      .sts_q    (sts_flat[l*STS_W +: STS_W]),
      .hit      (hit_vec[l]),
      .clr_zero (clr_zero_vec[l])
    );
  end

  lirq_line_ctl #(.NUM_LOC(NUM_LOC)) u_line (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .set_vec  (hit_vec),
    .drop_vec (clr_zero_vec),
    .line_q   (irq_line)
  );

  logic [31:0]      en_sel;
  logic [STS_W-1:0] sts_sel;
  always_comb begin
    en_sel  = '0;
    sts_sel = '0;
    for (int l = 0; l < NUM_LOC; l++) begin
      if (reg_loc == LOC_W'(l)) begin
        en_sel  = en_flat[l*32 +: 32];
        sts_sel = sts_flat[l*STS_W +: STS_W];
      end
    end
    case (reg_off)
      A_EN:    reg_rdata = en_sel;
      A_STS:   reg_rdata = {{(32-STS_W){1'b0}}, sts_sel};
      A_VEC:   reg_rdata = VEC;
      A_CAP:   reg_rdata = CAP;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker
  import lirq_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3,
  parameter int unsigned OFF_W   = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     act_vld,
  input logic [LOC_W-1:0]         act_loc,
  input logic                     reg_wr,
  input logic [LOC_W-1:0]         reg_loc,
  input logic [OFF_W-1:0]         reg_off,
  input logic [NUM_LOC-1:0]       hit_vec,
  input logic [NUM_LOC-1:0]       clr_zero_vec,
  input logic [NUM_LOC*32-1:0]    en_flat,
  input logic [NUM_LOC*STS_W-1:0] sts_flat,
  input logic                     irq_line
);
  // R3: an accepted event raises the shared line on the next edge
  assert_evt_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> irq_line);

  // R5: an emptying clear with no concurrent event drops the line
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|hit_vec) && (|clr_zero_vec)) |=> !irq_line);

  // R5: the line changes only for an accepted event or an emptying clear
  assert_line_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_line) |-> $past((|hit_vec) || (|clr_zero_vec)));

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_chk
    // R6: enable contents move only on a write from the active locality
    assert_en_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && act_vld && act_loc == LOC_W'(l) && reg_loc == LOC_W'(l)
        && reg_off == OFF_W'(OFF_EN)) |=> $stable(en_flat[l*32 +: 32]));

    // R4: status bits are lost only through a status write from the active locality
    assert_sts_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && act_vld && act_loc == LOC_W'(l) && reg_loc == LOC_W'(l)
        && reg_off == OFF_W'(OFF_STS))
      |=> (($past(sts_flat[l*STS_W +: STS_W]) & ~sts_flat[l*STS_W +: STS_W]) == '0));
  end
endmodule

bind loc_irq_unit lirq_checker #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .OFF_W(OFF_W)) u_lirq_chk (
  .clk          (clk),
  .rst_n        (rst_i_n),
  .act_vld      (act_vld),
  .act_loc      (act_loc),
  .reg_wr       (reg_wr),
  .reg_loc      (reg_loc),
  .reg_off      (reg_off),
  .hit_vec      (hit_vec),
  .clr_zero_vec (clr_zero_vec),
  .en_flat      (en_flat),
  .sts_flat     (sts_flat),
  .irq_line     (irq_line)
);

// File: tb/loc_irq_unit_bench.sv
`timescale 1ns/1ps
module loc_irq_unit_bench;
  localparam int NL = 5;
  localparam logic [11:0] O_EN = 12'h008, O_VEC = 12'h00C, O_STS = 12'h010, O_CAP = 12'h014;
  localparam logic [7:0]  SUPB = 8'h87;
  localparam logic [31:0] EMK  = 32'h8000_009F;

  logic clk = 1'b0;
  logic rst_n;
  logic act_vld, reg_wr, arb_chg_vld, eng_evt_vld;
  logic [2:0] act_loc, reg_loc, arb_chg_loc, eng_evt_loc;
  logic [11:0] reg_off;
  logic [31:0] reg_wdata;
  logic [7:0]  eng_evt_bits;
  logic [31:0] rdata, rdata_n;
  logic        line, line_n;

  always #5 clk = ~clk;

  loc_irq_unit u_loc_irq_unit (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_loc(act_loc),
    .reg_wr(reg_wr), .reg_loc(reg_loc), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .arb_chg_vld(arb_chg_vld), .arb_chg_loc(arb_chg_loc),
    .eng_evt_vld(eng_evt_vld), .eng_evt_loc(eng_evt_loc), .eng_evt_bits(eng_evt_bits),
    .irq_line(line));

  loc_irq_unit #(.STS_VALID_EN(1'b0)) u_nosv (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_loc(act_loc),
    .reg_wr(reg_wr), .reg_loc(reg_loc), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_n), .arb_chg_vld(arb_chg_vld), .arb_chg_loc(arb_chg_loc),
    .eng_evt_vld(eng_evt_vld), .eng_evt_loc(eng_evt_loc), .eng_evt_bits(eng_evt_bits),
    .irq_line(line_n));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_en [NL];
  logic [7:0]  m_sts [NL];
  logic        m_line;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; arb_chg_vld = 0; eng_evt_vld = 0; eng_evt_bits = 0;
    reg_wdata = 0; arb_chg_loc = 0; eng_evt_loc = 0;
  endtask

  // expected next state from the requirements, using the inputs now driven
  task automatic model_step();
    logic hit, drop;
    logic [7:0] ev, q, c, ns;
    logic wok;
    hit = 0; drop = 0;
    wok = reg_wr && act_vld && act_loc == reg_loc;
    for (int l = 0; l < NL; l++) begin
      ev = 0;
      if (arb_chg_vld && arb_chg_loc == 3'(l)) ev[2] = 1;
      if (eng_evt_vld && eng_evt_loc == 3'(l)) ev = ev | eng_evt_bits;
      q  = m_en[l][31] ? (ev & m_en[l][7:0] & SUPB) : 8'h0;
      c  = (wok && reg_loc == 3'(l) && reg_off == O_STS) ? (reg_wdata[7:0] & SUPB) : 8'h0;
      ns = (m_sts[l] & ~c) | q;
      if (q != 0) hit = 1;
      if (c != 0 && (m_sts[l] & SUPB) != 0 && ns == 0) drop = 1;
      m_sts[l] = ns;
      if (wok && reg_loc == 3'(l) && reg_off == O_EN) m_en[l] = reg_wdata & EMK;
    end
    if (hit) m_line = 1;
    else if (drop) m_line = 0;
  endtask

  // one clock: inputs set at the falling edge, state sampled at the next one
  task automatic cyc(input logic wr, input logic [2:0] loc, input logic [11:0] off,
                     input logic [31:0] wd, input logic av, input logic [2:0] al,
                     input logic ev, input logic [2:0] el, input logic [7:0] eb);
    reg_wr = wr; reg_loc = loc; reg_off = off; reg_wdata = wd;
    arb_chg_vld = av; arb_chg_loc = al;
    eng_evt_vld = ev; eng_evt_loc = el; eng_evt_bits = eb;
    model_step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [2:0] loc, input logic [11:0] off);
    reg_wr = 0; reg_loc = loc; reg_off = off;
    #1;
  endtask

  task automatic wr(input logic [2:0] loc, input logic [11:0] off, input logic [31:0] wd);
    cyc(1, loc, off, wd, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);
    idle(); act_vld = 0; act_loc = 0; reg_loc = 0; reg_off = 0;
    for (int l = 0; l < NL; l++) begin m_en[l] = 32'h8; m_sts[l] = 0; end
    m_line = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 line in reset", {31'b0, line}, 0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      rd(3'(l), O_EN);  chk("R1 enable reset", rdata, 32'h8);
      rd(3'(l), O_STS); chk("R1 status reset", rdata, 0);
    end
    rd(0, O_CAP); chk("R8 capability", rdata, 32'h97);
    chk("R9 capability without status-valid", rdata_n, 32'h95);
    rd(4, O_VEC); chk("R7 vector", rdata, 32'd11);
    rd(0, 12'h020); chk("R11 unmapped offset", rdata, 0);
    rd(6, O_EN);  chk("R11 locality out of range", rdata, 0);
    rd(5, O_STS); chk("R11 locality out of range", rdata, 0);

    act_vld = 1; act_loc = 2;
    wr(2, O_VEC, 32'hFFFF_FFFF);
    rd(2, O_VEC); chk("R7 vector write ignored", rdata, 32'd11);
    wr(1, O_EN, 32'hFFFF_FFFF);
    rd(1, O_EN); chk("R6 non-active enable write", rdata, 32'h8);
    wr(2, O_EN, 32'hFFFF_FFFF);
    rd(2, O_EN); chk("R2 enable mask", rdata, 32'h8000_009F);
    chk("R9 enable mask without status-valid", rdata_n, 32'h8000_009D);

    cyc(0, 0, 0, 0, 0, 0, 1, 3, 8'h01);
    rd(3, O_STS); chk("R3 event on disabled locality", rdata, 0);
    chk("R3 line stays low", {31'b0, line}, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 2, 8'h01);
    rd(2, O_STS); chk("R3 status set", rdata, 32'h01);
    chk("R3 line high", {31'b0, line}, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 2, 8'h02);
    rd(2, O_STS); chk("R3 status-valid set", rdata, 32'h03);
    chk("R9 status-valid never set", rdata_n, 32'h01);
    wr(2, O_STS, 32'h0000_0002);
    rd(2, O_STS); chk("R4 write-one-to-clear", rdata, 32'h01);
    chk("R5 line kept while bits remain", {31'b0, line}, 1);

    act_vld = 0;
    wr(2, O_STS, 32'hFF);
    rd(2, O_STS); chk("R6 status write without active locality", rdata, 32'h01);
    act_vld = 1; act_loc = 0;
    wr(0, O_EN, 32'h8000_0004);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
    rd(0, O_STS); chk("R3 locality-changed set", rdata, 32'h04);
    act_loc = 2;
    wr(2, O_STS, 32'h0000_0001);
    chk("R5 line drops though other locality pending", {31'b0, line}, 0);
    rd(0, O_STS); chk("R5 other locality untouched", rdata, 32'h04);

    cyc(1, 2, O_STS, 32'h80, 0, 0, 1, 2, 8'h80);
    rd(2, O_STS); chk("R10 set wins over clear", rdata, 32'h80);
    chk("R10 line high", {31'b0, line}, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [2:0] rl;
      logic [11:0] off;
      logic [31:0] wd;
      rl = 3'($urandom_range(0, 5));
      rd(rl, ($urandom_range(0, 1) == 0) ? O_EN : O_STS);
      if (rl < NL) chk("R3 R4 random readback", rdata,
                       (reg_off == O_EN) ? m_en[rl] : {24'h0, m_sts[rl]});
      else chk("R11 random readback", rdata, 0);
      act_vld = ($urandom_range(0, 7) != 0);
      act_loc = 3'($urandom_range(0, 5));
      r = $urandom_range(0, 3);
      off = (r == 0) ? O_EN : (r == 1) ? O_VEC : O_STS;
      wd = $urandom;
      if (off == O_EN && $urandom_range(0, 1) == 1) wd[31] = 1'b1;
      cyc($urandom_range(0, 2) == 0,
          ($urandom_range(0, 1) == 1) ? act_loc : 3'($urandom_range(0, 5)),
          off, wd,
          $urandom_range(0, 3) == 0, 3'($urandom_range(0, 5)),
          $urandom_range(0, 1) == 1, 3'($urandom_range(0, 5)),
          8'($urandom) & 8'h83);
      chk("R3 R5 random line", {31'b0, line}, {31'b0, m_line});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule